// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Address Filtering

This block receives asynchronous serial frames in an 8-bit frame format or a 9-bit frame format. It is meant for a node on a shared multidrop line. Each frame has one start bit, then the data bits LSB first, then one stop bit. The line is sampled with a baud tick that runs at sixteen times the bit rate. A received byte goes into a holding buffer, and a receive flag is raised. That flag stays set until software clears it.

Two hardware features sit on top of plain reception. The first is framing-error detection: a stop bit sampled low sets a sticky error flag. The second is address filtering. When filtering is enabled, the receive flag is raised only for frames whose byte matches this node's masked address or its broadcast address. In the 9-bit format, the ninth bit must also be 1, which marks the frame as an address frame. This saves software from inspecting every address frame that passes on the line.

One control bit decides how a single register bit is seen through the software-visible view. It shows either the framing-error flag or the upper frame-mode bit. A write to that view goes to whichever of the two is currently selected.

Top module: `uar_mp_rx`

## Requirements
- R1: After reset, rxFlag, feFlag, rxData, rxBit9, the upper mode bit and topBitRd are all 0.
- R2: The frame mode is {upper mode bit, modeLo}. Value 01 selects the 8-bit format. A valid frame loads its byte into rxData (first received bit in bit 0) and sets rxFlag. In this format rxBit9 takes the stop bit value.
- R3: Mode values 10 and 11 select the 9-bit format. The ninth received bit appears on rxBit9.
- R4: A stop bit sampled low sets feFlag and leaves rxData and rxFlag unchanged. The receiver then waits for the line to return high before it looks for a new start bit.
- R5: Hardware never clears feFlag. Only a write through the shared view, with feViewSel = 1, changes it. If a missing stop bit and such a write fall in the same cycle, feFlag ends up at 1.
- R6: With feViewSel = 1, topBitRd shows feFlag and writes go to feFlag. With feViewSel = 0, topBitRd shows the upper mode bit and writes go to that bit. The bit that is not selected keeps its value.
- R7: With addrFilterEn = 1 in the 9-bit format, a frame whose ninth bit is 0 never sets rxFlag.
- R8: With addrFilterEn = 1 in the 8-bit format, a frame sets rxFlag only if it has a valid stop bit and its byte hits the given or broadcast address.
- R9: Given-address hit: the byte equals nodeAddr in every position where nodeMask is 1. Positions where nodeMask is 0 are ignored.
- R10: Broadcast hit: the byte has a 1 in every position where (nodeAddr | nodeMask) is 1. A zero address with a zero mask therefore accepts any byte.
- R11: With addrFilterEn = 0, every frame with a valid stop bit is accepted, whatever its ninth bit.
- R12: A start edge whose line is high again at the middle of the start bit is discarded, and the receiver returns to idle.
- R13: A frame that completes while rxFlag is set is dropped, and rxData keeps its contents. A rxFlagClr in the completion cycle frees the buffer, so that frame is accepted.
- R14: Mode 00 disables reception. No frame sets rxFlag or feFlag, whatever addrFilterEn is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxdIn | input | 1 | Serial line, idle high |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| modeLo | input | 1 | Lower frame-mode bit |
| feViewSel | input | 1 | 1: shared bit is the framing-error flag; 0: it is the upper mode bit |
| topWrEn | input | 1 | Write strobe for the shared bit |
| topWrData | input | 1 | Value written to the shared bit |
| addrFilterEn | input | 1 | Enables address filtering |
| nodeAddr | input | 8 | This node's address |
| nodeMask | input | 8 | Address mask; 0 marks a don't-care position |
| rxFlagClr | input | 1 | Clears rxFlag |
| rxData | output | 8 | Received byte buffer |
| rxBit9 | output | 1 | Ninth bit, or the stop bit in 8-bit format |
| rxFlag | output | 1 | Receive flag |
| feFlag | output | 1 | Sticky framing-error flag |
| topBitRd | output | 1 | Read value of the shared bit |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a frame completion and a software clear of the receive flag. The second pair is a missing stop bit and a software write of 0 to the error flag. The bench provokes each pair by holding the clear or the write active for the whole frame. It releases the strobe only once the flag is seen high at a falling edge. A flag that rises while its clear is held proves that the set won the collision. The flag must then stay high after release, and the buffer must hold the new byte.

// File: rtl/uar_pkg.sv
package uar_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_BREAK
  } rxState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // sample one data bit at mid-bit
    logic frameEnd;  // stop bit sampled this cycle
    logic nineBit;   // current frame uses the 9-bit format
  } rxStrobe_t;

endpackage

// File: rtl/uar_rx_ctrl.sv
module uar_rx_ctrl
  import uar_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      rxdS,
  input  logic [1:0] modeSel,
  output rxStrobe_t stb
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] LAST8    = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] LAST9    = BIT_W'(DATA_W);

  rxState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitIdx;
  logic             nineLatch;
  logic [BIT_W-1:0] lastIdx;
  logic             startAbort;

  assign lastIdx = nineLatch ? LAST9 : LAST8;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bitIdx    <= '0;
      nineLatch <= 1'b0;
    end else if (baudTick) begin
      case (state)
        ST_IDLE: begin
          if (modeSel != 2'b00 && !rxdS) begin
            state     <= ST_START;
            cnt       <= '0;
            nineLatch <= modeSel[1];
          end
        end
        ST_START: begin
          if (cnt == MID_CNT) begin
            cnt    <= '0;
            bitIdx <= '0;
            state  <= rxdS ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == LAST_CNT) begin
            cnt <= '0;
            if (bitIdx == lastIdx) state <= ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == LAST_CNT) begin
            cnt   <= '0;
            state <= rxdS ? ST_IDLE : ST_BREAK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_BREAK: begin
          if (rxdS) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.shiftEn  = baudTick && state == ST_DATA  && cnt == LAST_CNT;
    stb.frameEnd = baudTick && state == ST_STOP  && cnt == LAST_CNT;
    stb.nineBit  = nineLatch;
    startAbort   = baudTick && state == ST_START && cnt == MID_CNT && rxdS;
  end

  // R12: a rejected start leaves the FSM idle
  p_glitch_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    startAbort |=> state == ST_IDLE);

  // R14: mode 00 never leaves idle
  p_mode0_idle_r14: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 && state == ST_IDLE) |=> state == ST_IDLE);

  // R4: a low stop bit holds off the next start search until the line is high
  p_break_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameEnd && !rxdS) |=> state == ST_BREAK);

  p_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shiftEn, stb.frameEnd, startAbort}));

endmodule

// File: rtl/uar_rx_dp.sv
module uar_rx_dp
  import uar_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxdIn,
  input  rxStrobe_t         stb,
  input  logic              addrFilterEn,
  input  logic [DATA_W-1:0] nodeAddr,
  input  logic [DATA_W-1:0] nodeMask,
  input  logic              rxFlagClr,
  input  logic              feViewSel,
  input  logic              topWrEn,
  input  logic              topWrData,
  output logic              rxdS,
  output logic              modeHi,
  output logic              topBitRd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxFlag,
  output logic              feFlag
);

  // Input synchronizer, idle-high
  logic [SYNC_STAGES-1:0] syncQ;
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) syncQ[g] <= !rstN ? 1'b1 : rxdIn;
      end else begin : gNext
        always_ff @(posedge clk) syncQ[g] <= !rstN ? 1'b1 : syncQ[g-1];
      end
    end
  endgenerate
  assign rxdS = syncQ[SYNC_STAGES-1];

  logic [DATA_W:0] shiftQ;
  always_ff @(posedge clk) begin
    if (!rstN)            shiftQ <= '0;
    else if (stb.shiftEn) shiftQ <= {rxdS, shiftQ[DATA_W:1]};
  end

  logic [DATA_W-1:0] frmData, bcastAddr;
  logic frmBit9, stopOk, givenHit, bcastHit, addrOk, flagFree, accept, feWr;

  always_comb begin
    frmData   = stb.nineBit ? shiftQ[DATA_W-1:0] : shiftQ[DATA_W:1];
    frmBit9   = stb.nineBit ? shiftQ[DATA_W] : rxdS;
    stopOk    = rxdS;
    givenHit  = ((frmData ^ nodeAddr) & nodeMask) == '0;
    bcastAddr = nodeAddr | nodeMask;
    bcastHit  = (~frmData & bcastAddr) == '0;
    addrOk    = !addrFilterEn ||
                ((givenHit || bcastHit) && (!stb.nineBit || frmBit9));
    flagFree  = !rxFlag || rxFlagClr;
    accept    = stb.frameEnd && stopOk && addrOk && flagFree;
    feWr      = topWrEn && feViewSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData <= '0;
      rxBit9 <= 1'b0;
      rxFlag <= 1'b0;
      feFlag <= 1'b0;
      modeHi <= 1'b0;
    end else begin
      if (accept) begin
        rxData <= frmData;
        rxBit9 <= frmBit9;
      end
      if (accept)         rxFlag <= 1'b1;
      else if (rxFlagClr) rxFlag <= 1'b0;
      if (stb.frameEnd && !stopOk) feFlag <= 1'b1;
      else if (feWr)               feFlag <= topWrData;
      if (topWrEn && !feViewSel) modeHi <= topWrData;
    end
  end

  assign topBitRd = feViewSel ? feFlag : modeHi;

  // R5: no hardware path clears the error flag
  p_fe_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (feFlag && !feWr) |=> feFlag);

  // R13: a held buffer does not change
  p_buf_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlag && !rxFlagClr) |=> $stable(rxData) && rxFlag);

  // R2: the flag only rises after a completed frame
  p_flag_src_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFlag) |-> $past(stb.frameEnd));

  // R4: a low stop bit never raises the flag
  p_bad_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameEnd && !rxdS && !rxFlag) |=> !rxFlag && feFlag);

  // R7: a data frame is filtered out in 9-bit format
  p_nine_filter_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameEnd && addrFilterEn && stb.nineBit && !shiftQ[DATA_W] && !rxFlag)
      |=> !rxFlag);

endmodule

// File: rtl/uar_mp_rx.sv
module uar_mp_rx
  import uar_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxdIn,
  input  logic              baudTick,
  input  logic              modeLo,
  input  logic              feViewSel,
  input  logic              topWrEn,
  input  logic              topWrData,
  input  logic              addrFilterEn,
  input  logic [DATA_W-1:0] nodeAddr,
  input  logic [DATA_W-1:0] nodeMask,
  input  logic              rxFlagClr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxFlag,
  output logic              feFlag,
  output logic              topBitRd
);

  rxStrobe_t stb;
  logic rxdS, modeHi;

  uar_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxdS(rxdS),
    .modeSel({modeHi, modeLo}), .stb(stb)
  );

  uar_rx_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .rxdIn(rxdIn), .stb(stb),
    .addrFilterEn(addrFilterEn), .nodeAddr(nodeAddr), .nodeMask(nodeMask),
    .rxFlagClr(rxFlagClr), .feViewSel(feViewSel), .topWrEn(topWrEn),
    .topWrData(topWrData), .rxdS(rxdS), .modeHi(modeHi), .topBitRd(topBitRd),
    .rxData(rxData), .rxBit9(rxBit9), .rxFlag(rxFlag), .feFlag(feFlag)
  );

endmodule

// File: tb/tb_uar_mp_rx.sv
module tb_uar_mp_rx;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxdIn = 1'b1;
  logic baudTick = 1'b1;
  logic modeLo = 1'b0, feViewSel = 1'b0, topWrEn = 1'b0, topWrData = 1'b0;
  logic addrFilterEn = 1'b0, rxFlagClr = 1'b0;
  logic [7:0] nodeAddr = 8'h00, nodeMask = 8'h00;
  logic [7:0] rxData;
  logic rxBit9, rxFlag, feFlag, topBitRd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uar_mp_rx dut (
    .clk(clk), .rstN(rstN), .rxdIn(rxdIn), .baudTick(baudTick),
    .modeLo(modeLo), .feViewSel(feViewSel), .topWrEn(topWrEn),
    .topWrData(topWrData), .addrFilterEn(addrFilterEn), .nodeAddr(nodeAddr),
    .nodeMask(nodeMask), .rxFlagClr(rxFlagClr), .rxData(rxData),
    .rxBit9(rxBit9), .rxFlag(rxFlag), .feFlag(feFlag), .topBitRd(topBitRd)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic       filt;
    logic [7:0] addr;
    logic [7:0] mask;
    logic [8:0] frame;
    logic       stop;
    logic       expFlag;
    logic       expFe;
    logic [7:0] expData;
    logic       expB9;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b0, 8'hC0, 8'hFD, 9'h05A, 1'b1, 1'b1, 1'b0, 8'h5A, 1'b1}, // R2
    '{2'd1, 1'b0, 8'hC0, 8'hFD, 9'h033, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0}, // R4
    '{2'd2, 1'b1, 8'hC0, 8'hFD, 9'h1C0, 1'b1, 1'b1, 1'b0, 8'hC0, 1'b1}, // R3 R9
    '{2'd2, 1'b1, 8'hC0, 8'hFD, 9'h1C2, 1'b1, 1'b1, 1'b0, 8'hC2, 1'b1}, // R9
    '{2'd2, 1'b1, 8'hC0, 8'hFD, 9'h1C1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // R9
    '{2'd3, 1'b1, 8'hC0, 8'hFD, 9'h0C0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // R7
    '{2'd3, 1'b1, 8'hC0, 8'hFD, 9'h1FD, 1'b1, 1'b1, 1'b0, 8'hFD, 1'b1}, // R10
    '{2'd1, 1'b1, 8'hC0, 8'hFD, 9'h0C0, 1'b1, 1'b1, 1'b0, 8'hC0, 1'b1}, // R8
    '{2'd1, 1'b1, 8'hC0, 8'hFD, 9'h012, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // R8
    '{2'd2, 1'b0, 8'hC0, 8'hFD, 9'h012, 1'b1, 1'b1, 1'b0, 8'h12, 1'b0}, // R11
    '{2'd1, 1'b1, 8'h00, 8'h00, 9'h077, 1'b1, 1'b1, 1'b0, 8'h77, 1'b1}, // R10
    '{2'd3, 1'b1, 8'hC0, 8'hFD, 9'h1F1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}, // R9 R10
    '{2'd1, 1'b1, 8'hC0, 8'hFD, 9'h0C0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0}  // R8 R4
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeTop(input logic view, input logic val);
    @(negedge clk);
    feViewSel = view; topWrData = val; topWrEn = 1'b1;
    @(negedge clk);
    topWrEn = 1'b0;
  endtask

  task automatic setMode(input logic [1:0] m);
    writeTop(1'b0, m[1]);
    modeLo = m[0];
    feViewSel = 1'b1;
  endtask

  task automatic clearFlags();
    @(negedge clk); rxFlagClr = 1'b1;
    @(negedge clk); rxFlagClr = 1'b0;
    writeTop(1'b1, 1'b0);
  endtask

  task automatic sendFrame(input logic [8:0] bits, input int nBits,
                           input logic stopV, input int extraLow);
    @(negedge clk); rxdIn = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      rxdIn = bits[i];
      repeat (16) @(negedge clk);
    end
    rxdIn = stopV;
    repeat (16) @(negedge clk);
    if (!stopV) repeat (extraLow) @(negedge clk);
    rxdIn = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("Watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rxFlag", rxFlag, 0);
    chk("R1 feFlag", feFlag, 0);
    chk("R1 rxData", rxData, 0);
    chk("R1 rxBit9", rxBit9, 0);
    chk("R1 topBitRd", topBitRd, 0);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      setMode(VECS[v].mode);
      addrFilterEn = VECS[v].filt;
      nodeAddr = VECS[v].addr;
      nodeMask = VECS[v].mask;
      clearFlags();
      sendFrame(VECS[v].frame, VECS[v].mode[1] ? 9 : 8, VECS[v].stop, 0);
      chk($sformatf("R2/R3/R7-R11 vec%0d rxFlag", v), rxFlag, VECS[v].expFlag);
      chk($sformatf("R4 vec%0d feFlag", v), feFlag, VECS[v].expFe);
      if (VECS[v].expFlag) begin
        chk($sformatf("R2 vec%0d rxData", v), rxData, VECS[v].expData);
        chk($sformatf("R3 vec%0d rxBit9", v), rxBit9, VECS[v].expB9);
      end
    end

    // R6 shared bit routing
    clearFlags();
    writeTop(1'b0, 1'b1);
    @(negedge clk); chk("R6 view mode bit", topBitRd, 1);
    feViewSel = 1'b1;
    @(negedge clk); chk("R6 view fe", topBitRd, 0);
    writeTop(1'b1, 1'b1);
    @(negedge clk); chk("R6 fe written", feFlag, 1);
    feViewSel = 1'b0;
    @(negedge clk); chk("R6 mode bit kept", topBitRd, 1);
    writeTop(1'b0, 1'b0);
    @(negedge clk); chk("R6 mode bit cleared", topBitRd, 0);
    chk("R6 fe untouched", feFlag, 1);
    writeTop(1'b1, 1'b0);

    // R13 overrun
    setMode(2'd1); addrFilterEn = 1'b0;
    clearFlags();
    sendFrame(9'h011, 8, 1'b1, 0);
    sendFrame(9'h022, 8, 1'b1, 0);
    chk("R13 overrun flag", rxFlag, 1);
    chk("R13 overrun data kept", rxData, 8'h11);

    // R13 clear in completion cycle: clear held until flag observed high
    fork
      sendFrame(9'h033, 8, 1'b1, 0);
      begin
        @(negedge clk); rxFlagClr = 1'b1;
        for (int k = 0; k < 400 && !rxFlag; k++) @(negedge clk);
        for (int k = 0; k < 400 && rxFlag; k++) @(negedge clk);
        for (int k = 0; k < 400 && !rxFlag; k++) @(negedge clk);
        rxFlagClr = 1'b0;
      end
    join
    chk("R13 set beats clear", rxFlag, 1);
    chk("R13 data after collision", rxData, 8'h33);

    // R5 hardware set beats software write in the same cycle
    clearFlags();
    fork
      sendFrame(9'h044, 8, 1'b0, 0);
      begin
        @(negedge clk); feViewSel = 1'b1; topWrData = 1'b0; topWrEn = 1'b1;
        for (int k = 0; k < 400 && !feFlag; k++) @(negedge clk);
        topWrEn = 1'b0;
      end
    join
    chk("R5 fe set wins", feFlag, 1);
    chk("R4 no flag on bad stop", rxFlag, 0);

    // R5 sticky across a good frame
    sendFrame(9'h055, 8, 1'b1, 0);
    chk("R5 fe sticky", feFlag, 1);
    chk("R5 good frame received", rxData, 8'h55);

    // R12 glitch rejection
    clearFlags();
    @(negedge clk); rxdIn = 1'b0;
    repeat (5) @(negedge clk);
    rxdIn = 1'b1;
    repeat (300) @(negedge clk);
    chk("R12 glitch no flag", rxFlag, 0);
    sendFrame(9'h06B, 8, 1'b1, 0);
    chk("R12 frame after glitch", rxData, 8'h6B);

    // R4 break: line stays low, then recovers
    clearFlags();
    sendFrame(9'h000, 8, 1'b0, 48);
    chk("R4 break no flag", rxFlag, 0);
    chk("R4 break fe", feFlag, 1);
    sendFrame(9'h04E, 8, 1'b1, 0);
    chk("R4 frame after break flag", rxFlag, 1);
    chk("R4 frame after break data", rxData, 8'h4E);

    // R14 mode 00 disables reception
    setMode(2'd0); addrFilterEn = 1'b1; nodeAddr = 8'h00; nodeMask = 8'h00;
    clearFlags();
    sendFrame(9'h0A5, 8, 1'b1, 0);
    chk("R14 mode0 filt on", rxFlag, 0);
    addrFilterEn = 1'b0;
    sendFrame(9'h0A5, 8, 1'b0, 0);
    chk("R14 mode0 filt off", rxFlag, 0);
    chk("R14 mode0 no fe", feFlag, 0);
    chk("R14 buffer kept", rxData, 8'h4E);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule